// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block is the coherence controller for one small direct-mapped, write-through data cache sitting on a shared, atomic bus next to other caches of the same kind. Each line is either valid or invalid. Processor reads that find their line valid finish locally. Reads that miss fetch the word over the bus and fill the line. Every processor write is sent to the bus whether or not the line is resident, so memory always holds the latest value.

The controller also watches the writes that other caches place on the bus. A matching resident line is dropped, so any number of caches may hold a copy for reading, but one write removes every other copy. The processor issues one operation at a time, holds it until a done pulse, and gets back a hit flag and, for reads, the data.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_done` and `bus_req` are low. The first read of any address is a miss.
- R2: A read that misses raises `bus_req` with `bus_we`=0 and the request address. When the bus transaction completes, the line is filled with `bus_rdata`, that word is returned on `cpu_rdata`, `cpu_hit` is 0, and the line becomes valid.
- R3: A read that hits a valid line raises no bus request. It pulses `cpu_done` in the cycle after the request is accepted, with `cpu_hit`=1 and the cached word on `cpu_rdata`.
- R4: Every write, hit or miss, raises `bus_req` with `bus_we`=1, `bus_addr`=`cpu_addr` and `bus_wdata`=`cpu_wdata`. `cpu_hit` reports whether the line was resident.
- R5: A write to a valid line with a matching tag also updates the cached word, so a later read hits and returns it. A write that misses allocates nothing, so a later read of that address misses.
- R6: A snooped write (`snp_vld`=1, `snp_we`=1) whose address matches a valid line makes that line invalid. The next read of that address misses.
- R7: A snooped read (`snp_we`=0), or a snooped write whose tag differs from the resident line at that index, leaves the line valid.
- R8: A snooped write to a line in the same cycle that a processor request looks that line up takes priority. The request sees a miss and goes to the bus.
- R9: `bus_req` stays high, with address, direction and write data held stable, until `bus_gnt`. The transaction takes place in the cycle `bus_gnt` is high, and `cpu_done` follows in the next cycle.
- R10: Addresses are word addresses. The line index is `addr[1:0]` and the tag is `addr[31:2]`, so two addresses with equal low bits evict each other.
- R11: `cpu_done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Line was resident at lookup |
| cpu_rdata | output | 32 | Read result |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_we | output | 1 | Transaction direction, 1 = write |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Transaction write data |
| bus_rdata | input | 32 | Memory read data during the granted cycle |
| snp_vld | input | 1 | Another cache's transaction is on the bus |
| snp_we | input | 1 | That transaction is a write |
| snp_addr | input | 32 | That transaction's address |

## Verification
The bench goes after write-through without allocation. A controller that allocates on a write miss would report a hit on the following read and skip the bus. It also checks that a write hit refreshes the cached word, since a stale copy would be returned on the next read hit. Snoop filtering is exercised with a read snoop and with a same-index, other-tag write snoop: a design that compares only the index would drop a line it should keep, while one that ignores snoops would keep serving a value another cache overwrote. The same-cycle snoop and lookup case catches a lookup that uses the pre-invalidation state and answers a hit. A delayed grant catches a request that drops early, changes its address, or completes before the bus is granted.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_BUS  = 2'd1,
    CTL_RESP = 2'd2
  } ctl_state_e;

  typedef enum logic {
    LN_INVALID = 1'b0,
    LN_VALID   = 1'b1
  } line_state_e;
endpackage

// File: rtl/wts_line_store.sv
module wts_line_store
  import wts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              sn_wr,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_match,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic              upd_en,
  output logic              upd_hit,
  output logic [LINES-1:0]  vld_vec
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  logic [IDX_W-1:0] lk_idx, sn_idx, wr_idx;
  assign lk_idx = line_index(lk_addr);
  assign sn_idx = line_index(sn_addr);
  assign wr_idx = line_index(wr_addr);

  assign sn_match = sn_wr && vld_vec[sn_idx] && (tag_a[sn_idx] == line_tag(sn_addr));
  // a snooped write to the same line wins over the lookup in that cycle
  assign lk_hit   = vld_vec[lk_idx] && (tag_a[lk_idx] == line_tag(lk_addr))
                    && !(sn_match && (sn_idx == lk_idx));
  assign lk_data  = data_a[lk_idx];
  assign upd_hit  = vld_vec[wr_idx] && (tag_a[wr_idx] == line_tag(wr_addr));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_state_e       st_q;
    logic [TAG_W-1:0]  tg_q;
    logic [DATA_W-1:0] dt_q;
    logic              sel_w, sel_s;

    assign sel_w = (wr_idx == IDX_W'(i));
    assign sel_s = sn_match && (sn_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= LN_INVALID;
        tg_q <= '0;
        dt_q <= '0;
      end else begin
        if (fill_en && sel_w) begin
          st_q <= LN_VALID;
          tg_q <= line_tag(wr_addr);
          dt_q <= wr_data;
        end else if (upd_en && upd_hit && sel_w) begin
          dt_q <= wr_data;
        end
        if (sel_s) st_q <= LN_INVALID;
      end
    end

    assign vld_vec[i] = (st_q == LN_VALID);
    assign tag_a[i]   = tg_q;
    assign data_a[i]  = dt_q;
  end
endmodule

// File: rtl/wts_ctl.sv
module wts_ctl
  import wts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              accept_evt,
  output logic              fill_en,
  output logic              upd_en,
  output logic [DATA_W-1:0] st_wdata
);
  ctl_state_e        state_q;
  logic              we_q, hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              xfer;

  assign accept_evt = (state_q == CTL_IDLE) && cpu_req;
  assign xfer       = (state_q == CTL_BUS) && bus_gnt;
  assign fill_en    = xfer && !we_q;
  assign upd_en     = xfer && we_q;
  assign st_wdata   = we_q ? wdata_q : bus_rdata;

  assign bus_req   = (state_q == CTL_BUS);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  assign cpu_done  = (state_q == CTL_RESP);
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        CTL_IDLE: if (cpu_req) begin
          addr_q  <= cpu_addr;
          we_q    <= cpu_we;
          wdata_q <= cpu_wdata;
          hit_q   <= lk_hit;
          if (!cpu_we && lk_hit) begin
            rdata_q <= lk_data;
            state_q <= CTL_RESP;
          end else begin
            state_q <= CTL_BUS;
          end
        end
        CTL_BUS: if (bus_gnt) begin
          if (!we_q) rdata_q <= bus_rdata;
          state_q <= CTL_RESP;
        end
        CTL_RESP: state_q <= CTL_IDLE;
        default:  state_q <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_vld,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr
);
  // internal events, named for the bound checker
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              sn_match;
  logic              accept_evt;
  logic              fill_en, upd_en, upd_hit;
  logic [DATA_W-1:0] st_wdata;
  logic [LINES-1:0]  vld_vec;

  wts_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_done   (cpu_done),
    .cpu_hit    (cpu_hit),
    .cpu_rdata  (cpu_rdata),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .accept_evt (accept_evt),
    .fill_en    (fill_en),
    .upd_en     (upd_en),
    .st_wdata   (st_wdata)
  );

  wts_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (cpu_addr),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .sn_wr    (snp_vld && snp_we),
    .sn_addr  (snp_addr),
    .sn_match (sn_match),
    .wr_addr  (bus_addr),
    .wr_data  (st_wdata),
    .fill_en  (fill_en),
    .upd_en   (upd_en),
    .upd_hit  (upd_hit),
    .vld_vec  (vld_vec)
  );
endmodule

// File: rtl/wts_checker.sv
module wts_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              lk_hit,
  input logic              sn_match,
  input logic              accept_evt,
  input logic              fill_en,
  input logic [LINES-1:0]  vld_vec
);
  localparam int IDX_W = $clog2(LINES);

  assert_read_hit_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !cpu_we && lk_hit |=> cpu_done && cpu_hit && !bus_req);

  assert_write_to_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && cpu_we |=> bus_req && bus_we
      && bus_addr == $past(cpu_addr) && bus_wdata == $past(cpu_wdata));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
      && $stable(bus_wdata));

  assert_grant_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> cpu_done && !bus_req);

  assert_snoop_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sn_match |=> !vld_vec[$past(snp_addr[IDX_W-1:0])]);

  assert_fill_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !sn_match |=> vld_vec[$past(bus_addr[IDX_W-1:0])]);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind wt_snoop_ctrl wts_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_done   (cpu_done),
  .cpu_hit    (cpu_hit),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .snp_addr   (snp_addr),
  .lk_hit     (lk_hit),
  .sn_match   (sn_match),
  .accept_evt (accept_evt),
  .fill_en    (fill_en),
  .vld_vec    (vld_vec)
);

// File: tb/wt_snoop_ctrl_test.sv
`timescale 1ns/1ps
module wt_snoop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_done, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        snp_vld, snp_we;
  logic [31:0] snp_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wt_snoop_ctrl uut (.*);

  // memory behind the bus: 16 words, preset to A000_0000 + index
  logic [31:0] mem [16];
  assign bus_rdata = mem[bus_addr[3:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
    end else if (bus_req && bus_gnt && bus_we) begin
      mem[bus_addr[3:0]] <= bus_wdata;
    end
  end

  // results of the last operation
  logic        o_hit, o_bwe, o_stable_bad;
  logic [31:0] o_rd, o_baddr, o_bwd;
  int          o_bus, o_wait, o_lat;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                       input int wait_n, input logic snp_same);
    int n, steps, gstep;
    logic fin;
    logic [31:0] a0;
    n = 0; steps = 0; gstep = 0; fin = 1'b0; a0 = '0;
    o_bus = 0; o_stable_bad = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (snp_same) begin snp_vld = 1'b1; snp_we = 1'b1; snp_addr = a; end
    while (!fin) begin
      @(negedge clk);
      steps++;
      snp_vld = 1'b0;
      bus_gnt = 1'b0;
      if (cpu_done) begin
        o_hit = cpu_hit; o_rd = cpu_rdata; o_wait = steps; o_lat = steps - gstep;
        cpu_req = 1'b0; fin = 1'b1;
      end else if (bus_req) begin
        if (n == 0) a0 = bus_addr;
        else if (bus_addr !== a0) o_stable_bad = 1'b1;
        if (n == wait_n) begin
          bus_gnt = 1'b1; o_bus++; o_bwe = bus_we; o_baddr = bus_addr;
          o_bwd = bus_wdata; gstep = steps;
        end
        n++;
      end
    end
  endtask

  task automatic snoop(input logic we, input logic [31:0] a);
    @(negedge clk);
    snp_vld = 1'b1; snp_we = we; snp_addr = a;
    @(negedge clk);
    snp_vld = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        exp_hit;
    logic        exp_bus;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd1,  32'h0,         1'b0, 1'b1, 32'hA000_0001}, // R1 R2 first read misses
    '{1'b0, 32'd1,  32'h0,         1'b1, 1'b0, 32'hA000_0001}, // R3 hit
    '{1'b1, 32'd1,  32'h1111_1111, 1'b1, 1'b1, 32'h0},         // R4 write hit on bus
    '{1'b0, 32'd1,  32'h0,         1'b1, 1'b0, 32'h1111_1111}, // R5 cache updated
    '{1'b1, 32'd6,  32'h2222_2222, 1'b0, 1'b1, 32'h0},         // R4 write miss on bus
    '{1'b0, 32'd6,  32'h0,         1'b0, 1'b1, 32'h2222_2222}, // R5 no allocation
    '{1'b0, 32'd6,  32'h0,         1'b1, 1'b0, 32'h2222_2222}, // R3 hit after fill
    '{1'b0, 32'd2,  32'h0,         1'b0, 1'b1, 32'hA000_0002}, // R10 same index other tag
    '{1'b0, 32'd6,  32'h0,         1'b0, 1'b1, 32'h2222_2222}, // R10 evicted
    '{1'b0, 32'd13, 32'h0,         1'b0, 1'b1, 32'hA000_000D}, // R10 index 1 tag 3
    '{1'b0, 32'd1,  32'h0,         1'b0, 1'b1, 32'h1111_1111}  // R10 R2 refetch
  };

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 1'b0; snp_vld = 1'b0; snp_we = 1'b0; snp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done after reset", 32'(cpu_done), 32'd0);
    check("R1 bus_req after reset", 32'(bus_req), 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      do_op(VECS[k].we, VECS[k].addr, VECS[k].wd, 0, 1'b0);
      check($sformatf("R3/R5 vec %0d hit", k), 32'(o_hit), 32'(VECS[k].exp_hit));
      check($sformatf("R2/R4 vec %0d bus count", k), 32'(o_bus), 32'(VECS[k].exp_bus));
      if (VECS[k].exp_bus) begin
        check($sformatf("R4 vec %0d bus_we", k), 32'(o_bwe), 32'(VECS[k].we));
        check($sformatf("R4 vec %0d bus_addr", k), o_baddr, VECS[k].addr);
        if (VECS[k].we) check($sformatf("R4 vec %0d bus_wdata", k), o_bwd, VECS[k].wd);
      end
      if (!VECS[k].we) check($sformatf("R2/R5 vec %0d rdata", k), o_rd, VECS[k].exp_rd);
    end

    // R7: snooped read leaves line 1 valid
    snoop(1'b0, 32'd1);
    do_op(1'b0, 32'd1, 32'h0, 0, 1'b0);
    check("R7 read snoop hit", 32'(o_hit), 32'd1);
    check("R7 read snoop no bus", 32'(o_bus), 32'd0);
    // R7: write snoop with other tag at same index
    snoop(1'b1, 32'd5);
    do_op(1'b0, 32'd1, 32'h0, 0, 1'b0);
    check("R7 other tag hit", 32'(o_hit), 32'd1);
    check("R7 other tag rdata", o_rd, 32'h1111_1111);
    // R6: matching write snoop invalidates
    snoop(1'b1, 32'd1);
    do_op(1'b0, 32'd1, 32'h0, 0, 1'b0);
    check("R6 after snoop hit", 32'(o_hit), 32'd0);
    check("R6 after snoop bus", 32'(o_bus), 32'd1);
    check("R6 refetch rdata", o_rd, 32'h1111_1111);
    // R8: snoop in the lookup cycle wins
    do_op(1'b0, 32'd1, 32'h0, 0, 1'b1);
    check("R8 same cycle hit", 32'(o_hit), 32'd0);
    check("R8 same cycle bus", 32'(o_bus), 32'd1);
    // R9: delayed grant
    do_op(1'b1, 32'd3, 32'h3333_3333, 3, 1'b0);
    check("R9 single transaction", 32'(o_bus), 32'd1);
    check("R9 address held", 32'(o_stable_bad), 32'd0);
    check("R9 done after grant", 32'(o_lat), 32'd1);
    check("R9 total wait", 32'(o_wait), 32'd5);
    @(negedge clk);
    check("R11 done is a pulse", 32'(cpu_done), 32'd0);
    // R3: hit latency of one cycle
    do_op(1'b0, 32'd1, 32'h0, 0, 1'b0);
    check("R3 hit latency", 32'(o_wait), 32'd1);
    check("R3 hit flag", 32'(o_hit), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule